// File: doc/BRIEF.md
# Omega-Flip Permutation Step

This block is one step of a bit-permutation engine for an n-bit word. Each operation pushes the word through exactly two network stages. Each stage is either an omega stage or a flip stage, and n control bits steer the stages. An omega stage is a perfect shuffle followed by a column of n/2 two-bit exchange switches. A flip stage is a column of exchange switches followed by the inverse shuffle, so it undoes an omega stage that uses the same controls. Chaining 2·log2(n) stages through the result register is enough to reach any permutation of the word. For n = 64 this takes three omega-omega steps followed by three flip-flip steps.

The hardware has four physical stages in the order omega, omega, flip, flip. Bypass muxes select which two stages act, according to a 2-bit mode. The result is registered, so the permuted word appears one clock after the strobe. Producing the control words for a given permutation is the job of the software or logic that drives the block.

Top module: `ofp_step`

## Requirements
- R1: While reset (`rst_n` low) is active, and on its release, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. Back-to-back operations are accepted every cycle.
- R3: In a cycle with `in_valid` low, `out_data` keeps its previous value, whatever `in_data`, `in_ctrl` or `in_mode` do.
- R4: Omega stage: for i < n/2, the shuffle moves bit i to position 2i and bit i+n/2 to position 2i+1. Switch k then swaps positions 2k and 2k+1 when its control bit k is 1.
- R5: Flip stage: switch k first swaps positions 2k and 2k+1 when its control bit k is 1. The inverse shuffle then moves bit 2i to position i and bit 2i+1 to position i+n/2.
- R6: Mode 2'b00 applies omega then omega. The first stage takes `in_ctrl[n/2-1:0]` and the second takes `in_ctrl[n-1:n/2]`. This split of the control word holds for every mode.
- R7: Mode 2'b11 applies flip then flip.
- R8: Mode 2'b01 applies omega then flip.
- R9: Mode 2'b10 applies flip then omega.
- R10: Every operation is a permutation: the number of ones in `out_data` equals the number of ones in the accepted `in_data`.
- R11: Take an omega-omega step with control {B,A}, then feed its result to a flip-flip step with control {A,B}. The second step returns the original word.
- R12: In modes 2'b01 and 2'b10, an all-zero control word leaves the data unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_mode | input | 2 | Stage pair: 00 oo, 01 of, 10 fo, 11 ff |
| in_data | input | WIDTH | Word to permute |
| in_ctrl | input | WIDTH | Switch controls; low half first stage, high half second |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | WIDTH | Permuted word, held between operations |

## Verification
The assertions assume that `in_valid`, `in_mode`, `in_data` and `in_ctrl` are known, non-X values at every rising edge once reset is released. The bench meets this by driving every input to a defined value during reset and by changing inputs only on falling edges. The identity and bit-count properties compare against the previous cycle's data. For this reason the bench never strobes `in_valid` in the first cycle after reset is released.

// File: rtl/ofp_pkg.sv
package ofp_pkg;

   typedef enum logic [1:0] {
      MODE_OO = 2'b00,
      MODE_OF = 2'b01,
      MODE_FO = 2'b10,
      MODE_FF = 2'b11
   } ofp_mode_e;

   typedef enum logic {
      KIND_OMEGA = 1'b0,
      KIND_FLIP  = 1'b1
   } ofp_kind_e;

   // Per physical stage: route through the shuffle wiring, enable the
   // switch column, and take the upper half of the control word.
   typedef struct packed {
      logic wire_en;
      logic sw_en;
      logic use_hi;
   } ofp_cfg_t;

   localparam int unsigned OFP_STAGES = 4;

endpackage

// File: rtl/ofp_swcol.sv
module ofp_swcol #(
   parameter int unsigned WIDTH = 64
) (
   input  logic [WIDTH-1:0]   x,
   input  logic [WIDTH/2-1:0] sel,
   input  logic               en,
   output logic [WIDTH-1:0]   y
);
   localparam int unsigned PAIRS = WIDTH / 2;

   for (genvar k = 0; k < PAIRS; k++) begin : g_pair
      logic swap;
      assign swap        = en & sel[k];
      assign y[2*k]      = swap ? x[2*k+1] : x[2*k];
      assign y[2*k+1]    = swap ? x[2*k]   : x[2*k+1];
   end

endmodule

// File: rtl/ofp_shuffle.sv
module ofp_shuffle #(
   parameter int unsigned WIDTH   = 64,
   parameter bit          INVERSE = 1'b0
) (
   input  logic [WIDTH-1:0] x,
   input  logic             en,
   output logic [WIDTH-1:0] y
);
   localparam int unsigned HALF = WIDTH / 2;

   logic [WIDTH-1:0] perm;

   for (genvar i = 0; i < HALF; i++) begin : g_map
      if (INVERSE) begin : g_inv
         assign perm[i]      = x[2*i];
         assign perm[i+HALF] = x[2*i+1];
      end else begin : g_fwd
         assign perm[2*i]    = x[i];
         assign perm[2*i+1]  = x[i+HALF];
      end
   end

   assign y = en ? perm : x;

endmodule

// File: rtl/ofp_stage.sv
module ofp_stage
   import ofp_pkg::*;
#(
   parameter int unsigned WIDTH = 64,
   parameter ofp_kind_e   KIND  = KIND_OMEGA
) (
   input  logic [WIDTH-1:0]   x,
   input  logic [WIDTH/2-1:0] ctrl_lo,
   input  logic [WIDTH/2-1:0] ctrl_hi,
   input  ofp_cfg_t           cfg,
   output logic [WIDTH-1:0]   y
);
   logic [WIDTH/2-1:0] sel;
   logic [WIDTH-1:0]   mid;

   assign sel = cfg.use_hi ? ctrl_hi : ctrl_lo;

   if (KIND == KIND_OMEGA) begin : g_omega
      ofp_shuffle #(.WIDTH(WIDTH), .INVERSE(1'b0)) u_wire (
         .x(x), .en(cfg.wire_en), .y(mid));
      ofp_swcol #(.WIDTH(WIDTH)) u_sw (
         .x(mid), .sel(sel), .en(cfg.sw_en), .y(y));
   end else begin : g_flip
      ofp_swcol #(.WIDTH(WIDTH)) u_sw (
         .x(x), .sel(sel), .en(cfg.sw_en), .y(mid));
      ofp_shuffle #(.WIDTH(WIDTH), .INVERSE(1'b1)) u_wire (
         .x(mid), .en(cfg.wire_en), .y(y));
   end

endmodule

// File: rtl/ofp_mode_dec.sv
module ofp_mode_dec
   import ofp_pkg::*;
(
   input  logic [1:0]                mode,
   output ofp_cfg_t [OFP_STAGES-1:0] cfg
);
   localparam ofp_cfg_t OFF  = '{wire_en: 1'b0, sw_en: 1'b0, use_hi: 1'b0};
   localparam ofp_cfg_t LO   = '{wire_en: 1'b1, sw_en: 1'b1, use_hi: 1'b0};
   localparam ofp_cfg_t HI   = '{wire_en: 1'b1, sw_en: 1'b1, use_hi: 1'b1};
   localparam ofp_cfg_t SWLO = '{wire_en: 1'b0, sw_en: 1'b1, use_hi: 1'b0};
   localparam ofp_cfg_t SWHI = '{wire_en: 1'b0, sw_en: 1'b1, use_hi: 1'b1};

   // Index 0..3 = omega, omega, flip, flip.
   always_comb begin
      unique case (ofp_mode_e'(mode))
         MODE_OO: cfg = {OFF,  OFF,  HI,  LO};
         MODE_FF: cfg = {HI,   LO,   OFF, OFF};
         MODE_OF: cfg = {OFF,  HI,   OFF, LO};
         // Flip then omega: the inverse shuffle and the shuffle cancel,
         // so only the two flip-side switch columns act, wiring bypassed.
         MODE_FO: cfg = {SWHI, SWLO, OFF, OFF};
         default: cfg = {OFF,  OFF,  OFF, OFF};
      endcase
   end

endmodule

// File: rtl/ofp_step.sv
module ofp_step
   import ofp_pkg::*;
#(
   parameter int unsigned WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_mode,
   input  logic [WIDTH-1:0] in_data,
   input  logic [WIDTH-1:0] in_ctrl,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_data
);
   localparam int unsigned HALF = WIDTH / 2;

   if (WIDTH < 4 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("ofp_step: WIDTH must be a power of two, at least 4");
   end

   ofp_cfg_t [OFP_STAGES-1:0] cfg;
   logic     [WIDTH-1:0]      link [OFP_STAGES+1];

   ofp_mode_dec u_dec (.mode(in_mode), .cfg(cfg));

   assign link[0] = in_data;

   for (genvar s = 0; s < OFP_STAGES; s++) begin : g_stage
      ofp_stage #(
         .WIDTH(WIDTH),
         .KIND ((s < OFP_STAGES/2) ? KIND_OMEGA : KIND_FLIP)
      ) u_stage (
         .x      (link[s]),
         .ctrl_lo(in_ctrl[HALF-1:0]),
         .ctrl_hi(in_ctrl[WIDTH-1:HALF]),
         .cfg    (cfg[s]),
         .y      (link[s+1])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= link[OFP_STAGES];
      end
   end

endmodule

// File: rtl/ofp_step_chk.sv
module ofp_step_chk
   import ofp_pkg::*;
#(
   parameter int unsigned WIDTH = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       in_mode,
   input logic [WIDTH-1:0] in_data,
   input logic [WIDTH-1:0] in_ctrl,
   input logic             out_valid,
   input logic [WIDTH-1:0] out_data
);
   assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));

   assert_ones_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ($countones(out_data) == $countones($past(in_data))));

   assert_zero_ctrl_identity_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_mode == MODE_OF || in_mode == MODE_FO) && in_ctrl == '0)
      |=> (out_data == $past(in_data)));

endmodule

bind ofp_step ofp_step_chk #(.WIDTH(WIDTH)) u_ofp_step_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
   .in_data(in_data), .in_ctrl(in_ctrl), .out_valid(out_valid),
   .out_data(out_data));

// File: tb/tb_ofp_step.sv
`timescale 1ns/1ps
module tb_ofp_step;
   localparam int W = 64;
   localparam int H = W / 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   in_mode = 2'b00;
   logic [W-1:0] in_data = '0;
   logic [W-1:0] in_ctrl = '0;
   logic         out_valid;
   logic [W-1:0] out_data;

   int checks = 0;
   int failures = 0;
   logic [W-1:0] seed = 64'h9E37_79B9_7F4A_7C15;

   always #2.5 clk = ~clk;

   ofp_step #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
      .in_data(in_data), .in_ctrl(in_ctrl), .out_valid(out_valid),
      .out_data(out_data));

   // ---- reference model, from the stage definitions ----
   function automatic logic [W-1:0] r_shuf(input logic [W-1:0] x);
      logic [W-1:0] y;
      for (int i = 0; i < H; i++) begin y[2*i] = x[i]; y[2*i+1] = x[i+H]; end
      return y;
   endfunction
   function automatic logic [W-1:0] r_unshuf(input logic [W-1:0] x);
      logic [W-1:0] y;
      for (int i = 0; i < H; i++) begin y[i] = x[2*i]; y[i+H] = x[2*i+1]; end
      return y;
   endfunction
   function automatic logic [W-1:0] r_ex(input logic [W-1:0] x, input logic [H-1:0] c);
      logic [W-1:0] y = x;
      for (int k = 0; k < H; k++)
         if (c[k]) begin y[2*k] = x[2*k+1]; y[2*k+1] = x[2*k]; end
      return y;
   endfunction
   function automatic logic [W-1:0] r_om(input logic [W-1:0] x, input logic [H-1:0] c);
      return r_ex(r_shuf(x), c);
   endfunction
   function automatic logic [W-1:0] r_fl(input logic [W-1:0] x, input logic [H-1:0] c);
      return r_unshuf(r_ex(x, c));
   endfunction
   function automatic logic [W-1:0] r_step(input logic [1:0] m, input logic [W-1:0] x,
                                           input logic [W-1:0] c);
      case (m)
         2'b00:   return r_om(r_om(x, c[H-1:0]), c[W-1:H]);
         2'b01:   return r_fl(r_om(x, c[H-1:0]), c[W-1:H]);
         2'b10:   return r_om(r_fl(x, c[H-1:0]), c[W-1:H]);
         default: return r_fl(r_fl(x, c[H-1:0]), c[W-1:H]);
      endcase
   endfunction

   function automatic logic [W-1:0] next_rand();
      seed ^= seed << 13;
      seed ^= seed >> 7;
      seed ^= seed << 17;
      return seed;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one operation, return the result one clock later.
   task automatic op(input logic [1:0] m, input logic [W-1:0] d, input logic [W-1:0] c,
                     output logic [W-1:0] res);
      @(negedge clk);
      in_valid = 1'b1; in_mode = m; in_data = d; in_ctrl = c;
      @(negedge clk);
      in_valid = 1'b0;
      check("R2 out_valid", {63'd0, out_valid}, 64'd1);
      res = out_data;
   endtask

   task automatic test_reset_r1();
      check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
      check("R1 data in reset", out_data, '0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after release", {63'd0, out_valid}, 64'd0);
      check("R1 data after release", out_data, '0);
   endtask

   task automatic test_omega_bits_r4();
      logic [W-1:0] r;
      op(2'b00, 64'h2, 64'h0, r);
      check("R4 shuffle bit1->4", r, 64'h10);
      op(2'b00, 64'h2, 64'h2, r);
      check("R4 switch1 bit1->6", r, 64'h40);
      op(2'b00, 64'h1 << 32, 64'h0, r);
      check("R4 upper half bit32->2", r, 64'h4);
   endtask

   task automatic test_flip_bits_r5();
      logic [W-1:0] r;
      op(2'b11, 64'h10, 64'h0, r);
      check("R5 unshuffle bit4->1", r, 64'h2);
      op(2'b11, 64'h10, 64'h4, r);
      check("R5 switch2 bit4->17", r, 64'h1 << 17);
   endtask

   task automatic test_mode(input logic [1:0] m, input string req);
      logic [W-1:0] r, d, c;
      for (int n = 0; n < 8; n++) begin
         d = next_rand(); c = next_rand();
         if (n == 0) d = '1;
         op(m, d, c, r);
         check(req, r, r_step(m, d, c));
         check("R10 ones kept", 64'($countones(r)), 64'($countones(d)));
      end
   endtask

   task automatic test_hold_r3();
      logic [W-1:0] r;
      op(2'b01, 64'hDEAD_BEEF_0123_4567, 64'hFFFF_0000_AAAA_5555, r);
      for (int n = 0; n < 3; n++) begin
         in_mode = 2'(n); in_data = next_rand(); in_ctrl = next_rand();
         @(negedge clk);
         check("R3 data held", out_data, r);
         check("R3 valid low", {63'd0, out_valid}, 64'd0);
      end
   endtask

   task automatic test_stream_r2();
      logic [W-1:0] d [4];
      logic [W-1:0] c [4];
      for (int n = 0; n < 4; n++) begin d[n] = next_rand(); c[n] = next_rand(); end
      @(negedge clk);
      for (int n = 0; n < 4; n++) begin
         in_valid = 1'b1; in_mode = 2'(n); in_data = d[n]; in_ctrl = c[n];
         @(negedge clk);
         check("R2 back-to-back valid", {63'd0, out_valid}, 64'd1);
         check("R2 back-to-back data", out_data, r_step(2'(n), d[n], c[n]));
      end
      in_valid = 1'b0;
      @(negedge clk);
      check("R2 valid drops", {63'd0, out_valid}, 64'd0);
   endtask

   task automatic test_roundtrip_r11();
      logic [W-1:0] x, y, z;
      logic [H-1:0] a, b;
      for (int n = 0; n < 4; n++) begin
         x = next_rand(); a = H'(next_rand()); b = H'(next_rand());
         op(2'b00, x, {b, a}, y);
         op(2'b11, y, {a, b}, z);
         check("R11 oo then ff restores", z, x);
      end
   endtask

   task automatic test_identity_r12();
      logic [W-1:0] x, r;
      x = next_rand();
      op(2'b01, x, '0, r);
      check("R12 of zero ctrl", r, x);
      op(2'b10, x, '0, r);
      check("R12 fo zero ctrl", r, x);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset_r1();
      test_omega_bits_r4();
      test_flip_bits_r5();
      test_mode(2'b00, "R6 mode oo");
      test_mode(2'b11, "R7 mode ff");
      test_mode(2'b01, "R8 mode of");
      test_mode(2'b10, "R9 mode fo");
      test_hold_r3();
      test_stream_r2();
      test_roundtrip_r11();
      test_identity_r12();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule